// File: doc/BRIEF.md
# NRZI Line Transmitter with Bit Stuffing

This block turns a stream of bytes handed over by packet-building logic into the two-wire differential line symbols of a full-speed or low-speed serial bus link. For every packet it puts a synchronisation pattern on the line first. It then sends the payload bits least significant bit first. Each bit is NRZI coded: a 0 toggles the line and a 1 leaves it unchanged. After six 1s in a row a 0 is inserted. The packet closes with an end-of-packet sequence, after which the block releases the line driver enable.

All logic runs in one clock domain at four times the bit rate. A free-running divider produces a one-cycle bit enable, so every line symbol lasts exactly four clocks and no derived clock is used. The byte source sees a one-cycle ready pulse one bit time before the current byte runs out. If the source has no byte at that pulse, the packet ends cleanly. If it withdraws its valid signal in the middle of a byte, the packet is aborted on purpose with a run of unchanged symbols that no receiver can accept. A speed select swaps the idle and active polarities for low-speed links.

Top module: `usb_nrzi_tx`

## Requirements
- R1: After reset and between packets, line_oe is 0, tx_ready is 0, and the pins sit at the idle (J) level. J is line_dp=1, line_dm=0 when low_speed=0, and line_dp=0, line_dm=1 when low_speed=1. K is the opposite of J. SE0 is both pins at 0.
- R2: Every line symbol of a packet, and the enable itself, holds for exactly DIV (4) clock cycles. Changes happen only on the divided bit enable.
- R3: A packet starts when tx_valid is 1 at a bit enable while idle. Its first eight symbols are K J K J K J K K.
- R4: Payload bytes follow the sync, least significant bit first, NRZI coded: a 0 bit changes the symbol (J to K or K to J) and a 1 bit keeps it.
- R5: After six consecutive 1 bits, counting the final 1 of the sync, a 0 bit (a transition) is inserted. The byte source is held for that bit time: no byte is lost and none is taken twice.
- R6: tx_ready is a single-cycle pulse, high only inside a packet, on the bit enable that starts the last bit of the current byte (the sync counts as a byte). A byte is taken when tx_valid is 1 during that pulse.
- R7: tx_valid at 0 during the ready pulse ends the packet after the current byte. At the sync's pulse this gives a packet with no payload.
- R8: A packet ends with SE0 for two bit times and J for one bit time. line_oe then falls.
- R9: With low_speed=1, every J and K of the packet and of idle appears with the swapped pin levels given in R1.
- R10: tx_valid at 0 at a bit enable that would start bit 1 to 6 of a byte aborts the packet. Seven further symbols repeat the current level with no stuffing, then the end-of-packet sequence of R8 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| low_speed | input | 1 | 1 selects low-speed line polarity |
| tx_data | input | 8 | Next payload byte |
| tx_valid | input | 1 | Byte source has data and the packet continues |
| tx_ready | output | 1 | Single-cycle pulse at which tx_data is taken |
| line_dp | output | 1 | Positive data line level |
| line_dm | output | 1 | Negative data line level |
| line_oe | output | 1 | Line driver enable |

## Verification
The main path is driven with payloads chosen to separate the coding rules. Runs of 0xFF force repeated stuffing and stalls of the byte source. All-zero bytes toggle the line every bit. A byte of five leading 1s can only produce a stuff bit if the trailing 1 of the sync is counted. Mixed bytes show the bit order. The same patterns are repeated with low-speed polarity to catch pin swaps. Directed runs cover an empty packet, a normal end at the ready pulse, and a mid-byte withdrawal that must produce the seven-symbol abort run. Every captured stream is compared symbol by symbol with a bench-side model, each symbol's four-clock hold is checked, and the number of bytes the block took is counted.

// File: rtl/usb_tx_pkg.sv
// Shared types for the NRZI line transmitter.
// Assumes: used by every module of the transmitter.
package usb_tx_pkg;

    // Line symbol held in the output register, before polarity mapping.
    typedef enum logic [1:0] {
        SYM_J   = 2'd0,
        SYM_K   = 2'd1,
        SYM_SE0 = 2'd2
    } line_sym_t;

    // Transmit sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DATA    = 3'd1,
        ST_ABORT   = 3'd2,
        ST_EOP_SE0 = 3'd3,
        ST_EOP_J   = 3'd4
    } tx_state_t;

endpackage

// File: rtl/usb_tx_tick.sv
// Bit-rate enable generator: divides the fast clock by DIV and emits a
// one-cycle enable, so all bit timing stays in one clock domain.
// Assumes: DIV >= 2; the enable runs freely from reset.
module usb_tx_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Counts fast-clock cycles within one bit time.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // The enable is never two cycles wide.
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/usb_tx_line_drv.sv
// Maps a line symbol to pin levels for the selected speed: low speed
// swaps the J and K levels, SE0 drives both pins low.
// Assumes: idle pins show J whenever the driver enable is low.
module usb_tx_line_drv
    import usb_tx_pkg::*;
(
    input  logic      low_speed,
    input  line_sym_t sym,
    input  logic      oe,
    output logic      dp,
    output logic      dm
);
    // Decodes symbol and speed into pin levels.
    always_comb begin
        if (oe && sym == SYM_SE0) begin
            dp = 1'b0;
            dm = 1'b0;
        end else if (oe && sym == SYM_K) begin
            dp = low_speed;
            dm = !low_speed;
        end else begin
            dp = !low_speed;
            dm = low_speed;
        end
    end

endmodule

// File: rtl/usb_tx_ctrl.sv
// Transmit sequencer: sends sync, stuffed NRZI payload and EOP, and
// handshakes bytes one bit time ahead through a one-byte holding register.
// Assumes: tick is a one-cycle enable per bit time; tx_valid stays high
// for the whole packet and is low at the ready pulse that ends it.
module usb_tx_ctrl
    import usb_tx_pkg::*;
#(
    parameter int          BYTE_W    = 8,
    parameter int          STUFF_RUN = 6,
    parameter logic [BYTE_W-1:0] SYNC_PAT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output line_sym_t         sym_q,
    output logic              oe_q
);
    localparam int IDX_W      = $clog2(BYTE_W);
    localparam int ONES_W     = $clog2(STUFF_RUN + 2);
    localparam int ABORT_ONES = STUFF_RUN + 1;
    localparam int CNT_W      = $clog2(ABORT_ONES + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0]  IDX_PRE  = IDX_W'(BYTE_W - 2);
    localparam logic [ONES_W-1:0] RUN_MAX  = ONES_W'(STUFF_RUN);

    tx_state_t          state;
    logic [BYTE_W-1:0]  sh, hold;
    logic               have_next;
    logic [IDX_W-1:0]   idx;
    logic [ONES_W-1:0]  ones, ones_next;
    logic [CNT_W-1:0]   cnt;
    line_sym_t          lvl, emit_sym;
    logic               next_bit, stuff_due;

    assign stuff_due = (ones == RUN_MAX);
    assign tx_ready  = (state == ST_DATA) && tick && !stuff_due && (idx == IDX_PRE);

    // Selects the next bit and its NRZI symbol.
    always_comb begin
        next_bit = 1'b1;
        if (state == ST_IDLE)             next_bit = SYNC_PAT[0];
        else if (state == ST_DATA) begin
            if (stuff_due)                next_bit = 1'b0;
            else if (idx == IDX_LAST)     next_bit = hold[0];
            else                          next_bit = sh[idx + 1'b1];
        end
        emit_sym  = next_bit ? lvl : ((lvl == SYM_J) ? SYM_K : SYM_J);
        ones_next = next_bit ? ones + 1'b1 : '0;
    end

    // Advances the sequencer and the line register once per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; sh <= '0; hold <= '0; have_next <= 1'b0;
            idx <= '0; ones <= '0; cnt <= '0; lvl <= SYM_J;
            sym_q <= SYM_J; oe_q <= 1'b0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: if (tx_valid) begin
                    sh <= SYNC_PAT; idx <= '0; have_next <= 1'b0;
                    ones <= ones_next; lvl <= emit_sym; sym_q <= emit_sym;
                    oe_q <= 1'b1; state <= ST_DATA;
                end
                ST_DATA: begin
                    if (stuff_due) begin
                        ones <= '0; lvl <= emit_sym; sym_q <= emit_sym;
                    end else if (idx == IDX_LAST) begin
                        if (have_next) begin
                            sh <= hold; have_next <= 1'b0; idx <= '0;
                            ones <= ones_next; lvl <= emit_sym; sym_q <= emit_sym;
                        end else begin
                            sym_q <= SYM_SE0; cnt <= '0; state <= ST_EOP_SE0;
                        end
                    end else if (idx < IDX_PRE && !tx_valid) begin
                        sym_q <= lvl; ones <= '0; cnt <= CNT_W'(1); state <= ST_ABORT;
                    end else begin
                        idx <= idx + 1'b1;
                        ones <= ones_next; lvl <= emit_sym; sym_q <= emit_sym;
                        if (tx_ready && tx_valid) begin
                            hold <= tx_data; have_next <= 1'b1;
                        end
                    end
                end
                ST_ABORT: begin
                    if (cnt < CNT_W'(ABORT_ONES)) begin
                        sym_q <= lvl; cnt <= cnt + 1'b1;
                    end else begin
                        sym_q <= SYM_SE0; cnt <= '0; state <= ST_EOP_SE0;
                    end
                end
                ST_EOP_SE0: begin
                    if (cnt == '0) cnt <= CNT_W'(1);
                    else begin
                        sym_q <= SYM_J; state <= ST_EOP_J;
                    end
                end
                ST_EOP_J: begin
                    oe_q <= 1'b0; sym_q <= SYM_J; lvl <= SYM_J;
                    ones <= '0; state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line register moves only on the bit enable.
    assert_hold_bit_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(sym_q) && $stable(oe_q)));

    // A full run of ones is always followed by a transition.
    assert_stuff_transition_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && tick && stuff_due) |=> (sym_q != $past(sym_q)));

    // The run counter never passes the stuffing limit.
    assert_ones_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_MAX);

    // The enable is released only after the closing J.
    assert_release_after_j_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_q) |-> ($past(sym_q) == SYM_J));

endmodule

// File: rtl/usb_nrzi_tx.sv
// NRZI line transmitter top: bit-enable divider, transmit sequencer and
// pin mapper.
// Assumes: clk runs at DIV times the bit rate; low_speed is constant
// during a packet.
module usb_nrzi_tx
    import usb_tx_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_speed,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_dp,
    output logic              line_dm,
    output logic              line_oe
);
    logic      tick;
    line_sym_t sym;

    usb_tx_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    usb_tx_ctrl #(.BYTE_W(BYTE_W), .STUFF_RUN(STUFF_RUN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .sym_q(sym), .oe_q(line_oe)
    );

    usb_tx_line_drv u_drv (
        .low_speed(low_speed), .sym(sym), .oe(line_oe),
        .dp(line_dp), .dm(line_dm)
    );

    // The ready pulse lasts one cycle.
    assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    // Ready is offered only while a packet is on the line.
    assert_ready_in_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> line_oe);

endmodule

// File: tb/tb_usb_nrzi_tx.sv
`timescale 1ns/1ps
// Bench for the NRZI line transmitter: a vector table of packets, then
// directed runs for reset, empty packet and mid-byte abort.
module tb_usb_nrzi_tx;
    logic clk = 1'b0, rst_n = 1'b0, low_speed = 1'b0, tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_ready, line_dp, line_dm, line_oe;

    int checks = 0, fails = 0;
    logic [1:0] expv [128];
    logic [1:0] cap  [128];
    int elen, ncap, hs, eones;
    logic elvl, els, hold_bad;

    // {low_speed, byte count[2:0], bytes (first byte in bits 7:0)}
    localparam logic [35:0] VEC [8] = '{
        {1'b0, 3'd1, 32'h000000A5},
        {1'b0, 3'd2, 32'h0000FFFF},
        {1'b0, 3'd3, 32'h00000000},
        {1'b0, 3'd1, 32'h0000001F},
        {1'b1, 3'd2, 32'h00003FC3},
        {1'b0, 3'd4, 32'h7E7EFE01},
        {1'b1, 3'd3, 32'h00FFFFFF},
        {1'b0, 3'd2, 32'h000080FC}
    };

    usb_nrzi_tx dut (
        .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .line_dp(line_dp),
        .line_dm(line_dm), .line_oe(line_oe)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench model: J is 10 at full speed and 01 at low speed; K inverts.
    function automatic logic [1:0] pins(input logic is_k, input logic ls);
        return (is_k ^ ls) ? 2'b01 : 2'b10;
    endfunction

    task automatic push(input logic [1:0] s);
        expv[elen] = s; elen++;
    endtask

    task automatic exp_bit(input logic b);
        if (!b) elvl = ~elvl;
        push(pins(elvl, els));
        eones = b ? eones + 1 : 0;
        if (eones == 6) begin
            elvl = ~elvl; push(pins(elvl, els)); eones = 0;
        end
    endtask

    task automatic exp_start(input logic ls);
        elen = 0; elvl = 1'b0; eones = 0; els = ls;
        for (int i = 0; i < 8; i++) exp_bit(i == 7);
    endtask

    task automatic exp_eop();
        push(2'b00); push(2'b00); push(pins(1'b0, els));
    endtask

    // Drives one packet and captures the line symbols it produces.
    task automatic run_packet(input logic ls, input int n, input logic [31:0] bytes,
                              input int abort_k);
        hs = 0; ncap = 0; hold_bad = 1'b0;
        @(negedge clk);
        low_speed = ls; tx_data = bytes[7:0]; tx_valid = 1'b1;
        fork
            begin : drive
                int k = 0;
                while (1) begin
                    @(negedge clk);
                    if (tx_ready) begin
                        if (k < n) begin
                            @(posedge clk); k++; hs++;
                            #1 tx_data = (k < n) ? bytes[8*k +: 8] : 8'h00;
                            if (k == abort_k) begin
                                repeat (9) @(posedge clk);
                                @(negedge clk); tx_valid = 1'b0;
                                break;
                            end
                        end else begin
                            tx_valid = 1'b0;
                            break;
                        end
                    end
                end
            end
            begin : capture
                int w = 0;
                while (!line_oe && w < 200) begin @(negedge clk); w++; end
                while (line_oe && ncap < 128) begin
                    cap[ncap] = {line_dp, line_dm}; ncap++;
                    for (int j = 0; j < 3; j++) begin
                        @(negedge clk);
                        if ({line_dp, line_dm, line_oe} != {cap[ncap-1], 1'b1}) hold_bad = 1'b1;
                    end
                    @(negedge clk);
                end
            end
        join
        repeat (6) @(negedge clk);
    endtask

    task automatic compare_stream(input string tag);
        int bad = -1;
        check(ncap == elen, {tag, " R8 symbol count"}, ncap, elen);
        for (int i = 0; i < elen && i < ncap; i++)
            if (bad < 0 && cap[i] != expv[i]) bad = i;
        check(bad < 0, {tag, " R3 R4 R5 symbol stream"},
              (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(expv[bad]));
        check(!hold_bad, {tag, " R2 four-clock hold"}, hold_bad, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        check(!line_oe && !tx_ready && line_dp && !line_dm, "R1 reset idle",
              {line_oe, tx_ready, line_dp, line_dm}, 4'b0010);
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        check(!line_oe && !tx_ready && line_dp && !line_dm, "R1 idle after reset",
              {line_oe, tx_ready, line_dp, line_dm}, 4'b0010);

        // Vector table: R3 R4 R5 R6 R8 R9
        foreach (VEC[v]) begin
            int n = int'(VEC[v][34:32]);
            exp_start(VEC[v][35]);
            for (int b = 0; b < n; b++)
                for (int i = 0; i < 8; i++) exp_bit(VEC[v][8*b + i]);
            exp_eop();
            run_packet(VEC[v][35], n, VEC[v][31:0], -1);
            compare_stream($sformatf("vec%0d", v));
            check(hs == n, "R6 R5 bytes taken", hs, n);
            if (VEC[v][35])
                check(!line_oe && !line_dp && line_dm, "R9 R1 low-speed idle",
                      {line_oe, line_dp, line_dm}, 3'b001);
        end

        // R7: empty packet, valid dropped at the sync's ready pulse
        exp_start(1'b0); exp_eop();
        run_packet(1'b0, 0, 32'h0, -1);
        compare_stream("R7 empty packet");
        check(hs == 0, "R7 no byte taken", hs, 0);

        // R10: valid withdrawn while the second byte is on the line
        exp_start(1'b0);
        for (int i = 0; i < 8; i++) exp_bit(1'b0);
        exp_bit(1'b1); exp_bit(1'b0);
        for (int i = 0; i < 7; i++) push(pins(elvl, els));
        exp_eop();
        run_packet(1'b0, 2, 32'h00005500, 2);
        compare_stream("R10 abort");
        check(hs == 2, "R10 bytes before abort", hs, 2);
        check(!line_oe && line_dp && !line_dm, "R1 idle after abort",
              {line_oe, line_dp, line_dm}, 3'b010);

        summary();
        $finish;
    end
endmodule